// File: doc/BRIEF.md
# Dual-Panel Passive LCD Line and Frame Timing

This block produces the line pulse, frame marker, AC-modulation output and gated shift clock for an 8-bit color passive LCD driven as two halves. Each shift clock carries one 4-bit nibble to the upper half and one 4-bit nibble to the lower half. A pixel period is one, two, three or four memory clocks, chosen by a 2-bit divisor field. A horizontal counter and a vertical counter place every output edge at a fixed pixel offset within the line and the frame.

The block runs on a timing clock at twice the memory-clock rate. One pixel period is therefore 2×(div+1) timing-clock cycles, and the shift clock gets high and low phases of exactly equal length. Every line holds the display width D=(hdisp+1)×8 pixels and the blank width N=(hblank+1)×8 pixels, plus 33 pixels of fixed overhead. Pixel pairs come in through a ready/valid input and are shown on the two nibble buses while the shift clock toggles.

Top module: `dpanel_lcd_timing`

## Requirements
- R1: A pixel period lasts 2×(cfg_div+1) clk cycles. Inside the display window the shift clock is high for the first cfg_div+1 cycles of each pixel and low for the rest.
- R2: A line lasts D+N+33 pixel periods, where D=(cfg_hdisp+1)×8 and N=(cfg_hblank+1)×8.
- R3: The line pulse is high for the first 9 pixel periods of each line (pixels 0 to 8).
- R4: Shift clock pulses occur only on pixels 22 to 21+D. This gives exactly D rising edges per line, and the first one comes 13 pixel periods after the line pulse falls. The shift clock stays low while the line pulse is high.
- R5: pix_ready is high for one clk cycle, at the last cycle of the pixel before each display-window pixel. The pair offered then is held on ud_o/ld_o for the whole next pixel, across the shift clock's falling edge. If pix_valid is low at that cycle, both buses carry 0.
- R6: ud_o and ld_o are 0 whenever the line pulse is high.
- R7: frame_o rises when pixel 23 of the last line of a frame begins. It falls when pixel 23 of line 0 begins. That gives a setup of (line length − 14) pixels before the line pulse's trailing edge and a hold of 14 pixels after it.
- R8: mod_o toggles once per frame, when pixel 43 of the last line begins. That is D+N−1 pixel periods before the trailing edge of the next line pulse, and frame_o is high whenever it toggles.
- R9: A frame holds cfg_vlast+1 lines, so frame_o rises once every (cfg_vlast+1)×(D+N+33) pixel periods.
- R10: While rst is high, every output is 0. After rst falls, the first clk edge starts pixel 0 of line 0, and both line_o and frame_o go high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, twice the memory-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hdisp | input | 7 | Display width in 8-pixel units, minus one |
| cfg_hblank | input | 5 | Blank width in 8-pixel units, minus one |
| cfg_vlast | input | 10 | Lines per frame minus one |
| cfg_div | input | 2 | Pixel period in memory clocks, minus one |
| pix_valid | input | 1 | Offered pixel pair is valid |
| pix_upper | input | 4 | Nibble for the upper panel half |
| pix_lower | input | 4 | Nibble for the lower panel half |
| pix_ready | output | 1 | Pair is taken at this clk edge |
| line_o | output | 1 | Line pulse |
| frame_o | output | 1 | Frame marker |
| mod_o | output | 1 | AC-modulation output |
| shift_o | output | 1 | Gated shift clock |
| ud_o | output | 4 | Upper-half data nibble |
| ld_o | output | 4 | Lower-half data nibble |

## Verification
Four relations are checked by assertions on every cycle. The shift clock and pix_ready never coincide with the line pulse. The nibble buses are blank under the line pulse. frame_o falls only while the line pulse is low. mod_o changes only while frame_o is high. Exact distances cannot be seen from a single cycle: pulse widths, line and frame periods, the 13-pixel lead-in, frame setup and hold, the modulation lead and the shift phase lengths. The directed scenarios measure these in clock cycles under four divisor and width settings. The scenarios also follow each accepted pair to the falling shift edge, including a run where pix_valid stays low.

// File: rtl/dpanel_lcd_timing.sv
module dpanel_lcd_timing #(
  parameter int HDW  = 7,
  parameter int NDW  = 5,
  parameter int VW   = 10,
  parameter int DIVW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [HDW-1:0]  cfg_hdisp,
  input  logic [NDW-1:0]  cfg_hblank,
  input  logic [VW-1:0]   cfg_vlast,
  input  logic [DIVW-1:0] cfg_div,
  input  logic            pix_valid,
  input  logic [3:0]      pix_upper,
  input  logic [3:0]      pix_lower,
  output logic            pix_ready,
  output logic            line_o,
  output logic            frame_o,
  output logic            mod_o,
  output logic            shift_o,
  output logic [3:0]      ud_o,
  output logic [3:0]      ld_o
);

  localparam int HW = $clog2((2**HDW)*8 + (2**NDW)*8 + 34);
  localparam logic [HW-1:0] PULSE_END = HW'(9);
  localparam logic [HW-1:0] SHIFT_BEG = HW'(22);
  localparam logic [HW-1:0] FRAME_AT  = HW'(23);
  localparam logic [HW-1:0] MOD_AT    = HW'(43);
  localparam logic [HW-1:0] OVERHEAD  = HW'(33);

  logic [DIVW-1:0] hc;
  logic            ph;
  logic [HW-1:0]   h;
  logic [VW-1:0]   v;

  logic [HW-1:0] disp_px, blank_px, h_last;
  assign disp_px  = HW'({cfg_hdisp, 3'b000}) + HW'(8);
  assign blank_px = HW'({cfg_hblank, 3'b000}) + HW'(8);
  assign h_last   = disp_px + blank_px + OVERHEAD - HW'(1);

  logic half_end, pend, h_wrap, ph_n, win_n, frame_n, mod_hit;
  logic [HW-1:0] h_n;
  logic [VW-1:0] v_n;

  assign half_end = (hc == cfg_div);
  assign pend     = half_end & ph;
  assign h_wrap   = (h >= h_last);
  assign ph_n     = ph ^ half_end;
  assign h_n      = pend ? (h_wrap ? '0 : h + HW'(1)) : h;
  assign v_n      = (pend && h_wrap) ? ((v >= cfg_vlast) ? '0 : v + VW'(1)) : v;
  assign win_n    = (h_n >= SHIFT_BEG) && (h_n < SHIFT_BEG + disp_px);
  assign frame_n  = ((v_n == cfg_vlast) && (h_n >= FRAME_AT)) ||
                    ((v_n == '0) && (h_n < FRAME_AT));
  assign mod_hit  = pend && (h_n == MOD_AT) && (v_n == cfg_vlast);
  assign pix_ready = pend & win_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      hc      <= '0;
      ph      <= 1'b0;
      h       <= '0;
      v       <= '0;
      line_o  <= 1'b0;
      frame_o <= 1'b0;
      mod_o   <= 1'b0;
      shift_o <= 1'b0;
      ud_o    <= 4'h0;
      ld_o    <= 4'h0;
    end else begin
      hc      <= half_end ? '0 : hc + DIVW'(1);
      ph      <= ph_n;
      h       <= h_n;
      v       <= v_n;
      line_o  <= (h_n < PULSE_END);
      shift_o <= win_n & ~ph_n;
      frame_o <= frame_n;
      if (mod_hit) mod_o <= ~mod_o;
      if (pend) begin
        ud_o <= (pix_ready && pix_valid) ? pix_upper : 4'h0;
        ld_o <= (pix_ready && pix_valid) ? pix_lower : 4'h0;
      end
    end
  end

  AST_SHIFT_GATED: assert property (@(posedge clk) disable iff (rst)
    shift_o |-> !line_o); // R4

  AST_READY_OFF_PULSE: assert property (@(posedge clk) disable iff (rst)
    pix_ready |-> !line_o); // R5

  AST_DATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    line_o |-> (ud_o == 4'h0 && ld_o == 4'h0)); // R6

  AST_FRAME_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_o) |-> !line_o); // R7

  AST_MOD_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    !$stable(mod_o) |-> frame_o); // R8

endmodule

// File: tb/dpanel_lcd_timing_test.sv
module dpanel_lcd_timing_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] cfg_hdisp = '0;
  logic [4:0] cfg_hblank = '0;
  logic [9:0] cfg_vlast = '0;
  logic [1:0] cfg_div = '0;
  logic pix_valid = 1'b0;
  logic [3:0] pix_upper = '0, pix_lower = '0;
  logic pix_ready, line_o, frame_o, mod_o, shift_o;
  logic [3:0] ud_o, ld_o;

  always #5 clk = ~clk;

  dpanel_lcd_timing uut (
    .clk(clk), .rst(rst), .cfg_hdisp(cfg_hdisp), .cfg_hblank(cfg_hblank),
    .cfg_vlast(cfg_vlast), .cfg_div(cfg_div), .pix_valid(pix_valid),
    .pix_upper(pix_upper), .pix_lower(pix_lower), .pix_ready(pix_ready),
    .line_o(line_o), .frame_o(frame_o), .mod_o(mod_o), .shift_o(shift_o),
    .ud_o(ud_o), .ld_o(ld_o));

  int total = 0, bad = 0;
  int cyc, t_lr, t_lf, t_fr, t_md, t_shr;
  int lper, lwid, lead, sh_high, nsh, nsh_last, fsetup, fhold, fper, mtt, nmod;
  int dcnt, dbad, ibad, nrdy;
  bit first, frp, mdp, adv;
  logic p_line, p_sh, p_fr, p_md;
  logic [3:0] exp_u, exp_l;
  logic [7:0] k = 8'h3c;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst) begin
        cyc = 0; t_lr = -1; t_lf = 0; t_fr = -1; t_md = 0; t_shr = 0;
        lper = 0; lwid = 0; lead = 0; sh_high = 0; nsh = 0; nsh_last = 0;
        fsetup = 0; fhold = 0; fper = 0; mtt = 0; nmod = 0;
        dcnt = 0; dbad = 0; ibad = 0; nrdy = 0;
        first = 0; frp = 0; mdp = 0; adv = 0;
        exp_u = 0; exp_l = 0;
      end else begin
        cyc++;
        if (!shift_o && p_sh) begin
          sh_high = cyc - t_shr;
          dcnt++;
          if (ud_o !== exp_u || ld_o !== exp_l) dbad++;
        end
        if (shift_o && !p_sh) begin
          nsh++; t_shr = cyc;
          if (first) begin lead = cyc - t_lf; first = 0; end
        end
        if (line_o && !p_line) begin
          if (t_lr >= 0) lper = cyc - t_lr;
          t_lr = cyc; nsh_last = nsh; nsh = 0; first = 1;
        end
        if (!line_o && p_line) begin
          lwid = cyc - t_lr; t_lf = cyc;
          if (frp) begin fsetup = cyc - t_fr; frp = 0; end
          if (mdp) begin mtt = cyc - t_md; mdp = 0; end
        end
        if (frame_o && !p_fr) begin
          if (t_fr >= 0) fper = cyc - t_fr;
          t_fr = cyc; frp = 1;
        end
        if (!frame_o && p_fr) fhold = cyc - t_lf;
        if (mod_o != p_md) begin t_md = cyc; mdp = 1; nmod++; end
        if (line_o && (ud_o != 0 || ld_o != 0)) ibad++;
        if (adv) begin
          k = k + 8'd7; pix_upper = k[3:0]; pix_lower = k[7:4] ^ 4'h5; adv = 0;
        end
        if (pix_ready) begin
          nrdy++;
          exp_u = pix_valid ? pix_upper : 4'h0;
          exp_l = pix_valid ? pix_lower : 4'h0;
          adv = 1;
        end
      end
      p_line = line_o; p_sh = shift_o; p_fr = frame_o; p_md = mod_o;
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic test_reset();
    cfg_div = 2'd0; cfg_hdisp = 7'd3; cfg_hblank = 5'd1; cfg_vlast = 10'd3;
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R10 outputs low in reset", {28'd0, line_o, frame_o, mod_o, shift_o}, 0);
    chk("R10 buses low in reset", {24'd0, ud_o, ld_o}, 0);
    chk("R10 ready low in reset", {31'd0, pix_ready}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 line high after release", {31'd0, line_o}, 1);
    chk("R10 frame high after release", {31'd0, frame_o}, 1);
  endtask

  task automatic run_scn(string name, int div, int hd, int hb, int vl, bit valid);
    int p, d, n, ht, fr;
    p = 2 * (div + 1); d = (hd + 1) * 8; n = (hb + 1) * 8; ht = d + n + 33;
    fr = (vl + 1) * ht * p;
    cfg_div = 2'(div); cfg_hdisp = 7'(hd); cfg_hblank = 5'(hb); cfg_vlast = 10'(vl);
    pix_valid = valid;
    do_reset();
    repeat (3 * fr + 4 * ht * p) @(posedge clk);
    @(negedge clk);
    $display("scenario %s", name);
    chk("R1 shift high phase", sh_high, div + 1);
    chk("R2 line period", lper, ht * p);
    chk("R3 line pulse width", lwid, 9 * p);
    chk("R4 shift lead-in", lead, 13 * p);
    chk("R4 shift pulses per line", nsh_last, d);
    chk("R5 data on shift fall", dbad, 0);
    chk("R5 data samples seen", dcnt > 0, 1);
    chk("R5 ready seen", nrdy > 0, 1);
    chk("R6 buses idle under pulse", ibad, 0);
    chk("R7 frame setup", fsetup, (ht - 14) * p);
    chk("R7 frame hold", fhold, 14 * p);
    chk("R8 mod lead", mtt, (d + n - 1) * p);
    chk("R8 mod toggled", nmod > 1, 1);
    chk("R9 frame period", fper, fr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    test_reset();
    run_scn("fast", 0, 3, 1, 3, 1'b1);
    run_scn("slow_min_line", 3, 0, 0, 2, 1'b1);
    run_scn("starved", 1, 1, 2, 2, 1'b0);
    run_scn("wide", 2, 7, 3, 1, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule